// File: doc/BRIEF.md
# Page-bounded write request splitter

This block accepts a single write or erase request for a byte-addressed paged memory. Each request is a start address and a byte count. The block turns the request into a series of chunks, and no chunk crosses a page boundary. It passes each chunk to a downstream memory sequencer as a start address and a length. It then waits for that chunk's completion report before it offers the next one. The block keeps the running address and the remaining count. It stops at the first chunk the sequencer reports as failed. It finishes every request with a one-cycle completion pulse and an error flag.

While a chunk transfers, the sequencer pulls data bytes through the block. For a write request, each byte comes from the requester's data port. For an erase request, the block supplies the fill value itself and does not touch the requester's port.

Requests that run past the end of memory are refused before any chunk is issued. Zero-length requests complete at once, with success.

Top module: `page_split_top`

## Requirements
- R1: Each offered chunk length equals the smaller of the remaining count and PAGE_BYTES minus (chunk address modulo PAGE_BYTES). A chunk therefore never crosses a page boundary and is never zero.
- R2: The first chunk starts at the request address. Each later chunk starts at the previous chunk address plus the previous length. On success, the chunk lengths add up to the request count.
- R3: When the sequencer reports a chunk failure (`seq_err` high together with `seq_done`), no further chunk is offered. The request then completes with `err` = 1.
- R4: For an erase request (`req_erase` = 1), `chunk_erase` is 1, `seq_byte` is the fill value 8'hFF, and `host_byte_rd` stays 0 even while `seq_byte_rd` is 1.
- R5: For a write request (`req_erase` = 0), `chunk_erase` is 0, `seq_byte` equals `host_byte`, and `host_byte_rd` follows `seq_byte_rd`.
- R6: A request with address plus count greater than MEM_BYTES issues no chunk. It completes with `done` = 1 and `err` = 1 in the cycle after acceptance.
- R7: A request with count 0 issues no chunk. It completes with `done` = 1 and `err` = 0 in the cycle after acceptance.
- R8: A request is accepted only when `req_valid` and `req_ready` are both 1. `busy` is 1 from the cycle after acceptance until the completion pulse, and `req_ready` is its inverse. A request presented while busy is ignored and does not change the chunk stream.
- R9: `done` is a single-cycle pulse. `err` is valid with it, and `err` is 0 when every chunk succeeded.
- R10: `chunk_valid` holds, with stable `chunk_addr` and `chunk_len`, until `chunk_ready`. After acceptance, no chunk is offered until `seq_done`.
- R11: During and right after reset, `busy`, `done` and `chunk_valid` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | ADDR_W | Request start address |
| req_count | input | CNT_W | Request byte count |
| req_erase | input | 1 | 1 = erase with fill value, 0 = write host data |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Error status, valid with done |
| chunk_valid | output | 1 | Chunk offered to sequencer |
| chunk_ready | input | 1 | Sequencer takes the offered chunk |
| chunk_addr | output | ADDR_W | Chunk start address |
| chunk_len | output | log2(PAGE_BYTES)+1 | Chunk length in bytes |
| chunk_erase | output | 1 | Current request is an erase |
| seq_done | input | 1 | Sequencer finished the accepted chunk |
| seq_err | input | 1 | Sequencer chunk failed, valid with seq_done |
| seq_byte_rd | input | 1 | Sequencer takes a data byte |
| seq_byte | output | DATA_W | Data byte to sequencer |
| host_byte_rd | output | 1 | Byte taken from requester |
| host_byte | input | DATA_W | Data byte from requester |

## Verification
The bench builds the block with an 8-byte page, a 256-byte memory, 8-bit addresses and a 9-bit count. These small values make several cases reachable in a short run:
- a whole-memory erase, which produces 32 chunks;
- requests that end exactly at the top address;
- a count of 257, which is one past the end of memory.

Odd and even page offsets give short first chunks, short last chunks and requests that fit inside one page. Injected failures on the first and a middle chunk check that the block stops early.

// File: rtl/page_split_pkg.sv
package page_split_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } split_state_e;

endpackage

// File: rtl/page_split_len.sv
// Chunk length: min(remaining, bytes left in current page).
module page_split_len #(
  parameter int PAGE_BYTES = 16,
  parameter int CNT_W      = 12,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int LEN_W     = OFS_W + 1
) (
  input  logic [OFS_W-1:0] page_ofs,
  input  logic [CNT_W-1:0] remain,
  output logic [LEN_W-1:0] len
);

  logic [LEN_W-1:0] room;

  always_comb begin
    room = LEN_W'(PAGE_BYTES) - {1'b0, page_ofs};
    if (remain < CNT_W'(room)) begin
      len = remain[LEN_W-1:0];
    end else begin
      len = room;
    end
  end

endmodule

// File: rtl/page_split_range.sv
// Rejects requests running past the end of memory.
module page_split_range #(
  parameter int ADDR_W    = 11,
  parameter int CNT_W     = 12,
  parameter int MEM_BYTES = 2048,
  localparam int SUM_W    = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  output logic              out_of_range
);

  logic [SUM_W-1:0] end_excl;

  always_comb begin
    end_excl     = SUM_W'(addr) + SUM_W'(count);
    out_of_range = end_excl > SUM_W'(MEM_BYTES);
  end

endmodule

// File: rtl/page_split_fill.sv
// Data path: host bytes for writes, fill value for erases.
module page_split_fill #(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL   = '1
) (
  input  logic              erase_mode,
  input  logic              seq_byte_rd,
  input  logic [DATA_W-1:0] host_byte,
  output logic [DATA_W-1:0] seq_byte,
  output logic              host_byte_rd
);

  always_comb begin
    if (erase_mode) begin
      seq_byte     = FILL;
      host_byte_rd = 1'b0;
    end else begin
      seq_byte     = host_byte;
      host_byte_rd = seq_byte_rd;
    end
  end

endmodule

// File: rtl/page_split_ctrl.sv
// Request sequencing: accept, issue chunks one at a time, finish.
module page_split_ctrl
  import page_split_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 12,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_erase,
  input  logic              range_bad,
  input  logic [LEN_W-1:0]  calc_len,
  input  logic              chunk_ready,
  input  logic              seq_done,
  input  logic              seq_err,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              chunk_valid,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_remain,
  output logic              erase_mode
);

  split_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              erase_q, erase_d;
  logic              err_q, err_d;
  logic              ctx_en, len_en, err_en;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    len_d    = len_q;
    erase_d  = erase_q;
    err_d    = err_q;
    ctx_en   = 1'b0;
    len_en   = 1'b0;
    err_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ctx_en   = 1'b1;
          err_en   = 1'b1;
          addr_d   = req_addr;
          remain_d = req_count;
          erase_d  = req_erase;
          if (req_count == '0) begin
            err_d   = 1'b0;
            state_d = ST_DONE;
          end else if (range_bad) begin
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            err_d   = 1'b0;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (chunk_ready) begin
          len_en  = 1'b1;
          len_d   = calc_len;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (seq_done) begin
          if (seq_err) begin
            err_en  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            ctx_en   = 1'b1;
            addr_d   = addr_q + ADDR_W'(len_q);
            remain_d = remain_q - CNT_W'(len_q);
            if (remain_q == CNT_W'(len_q)) begin
              state_d = ST_DONE;
            end else begin
              state_d = ST_ISSUE;
            end
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      remain_q <= '0;
      erase_q  <= 1'b0;
    end else if (ctx_en) begin
      addr_q   <= addr_d;
      remain_q <= remain_d;
      erase_q  <= erase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign busy        = (state_q != ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign err         = err_q;
  assign chunk_valid = (state_q == ST_ISSUE);
  assign cur_addr    = addr_q;
  assign cur_remain  = remain_q;
  assign erase_mode  = erase_q;

endmodule

// File: rtl/page_split_top.sv
module page_split_top #(
  parameter int                ADDR_W     = 11,
  parameter int                CNT_W      = 12,
  parameter int                MEM_BYTES  = 2048,
  parameter int                PAGE_BYTES = 16,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] FILL       = '1,
  localparam int               OFS_W      = $clog2(PAGE_BYTES),
  localparam int               LEN_W      = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_erase,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              chunk_valid,
  input  logic              chunk_ready,
  output logic [ADDR_W-1:0] chunk_addr,
  output logic [LEN_W-1:0]  chunk_len,
  output logic              chunk_erase,
  input  logic              seq_done,
  input  logic              seq_err,
  input  logic              seq_byte_rd,
  output logic [DATA_W-1:0] seq_byte,
  output logic              host_byte_rd,
  input  logic [DATA_W-1:0] host_byte
);

  logic              range_bad;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_remain;
  logic [LEN_W-1:0]  calc_len;
  logic              erase_mode;

  page_split_range #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MEM_BYTES(MEM_BYTES)
  ) range_i (
    .addr        (req_addr),
    .count       (req_count),
    .out_of_range(range_bad)
  );

  page_split_len #(
    .PAGE_BYTES(PAGE_BYTES),
    .CNT_W     (CNT_W)
  ) len_i (
    .page_ofs(cur_addr[OFS_W-1:0]),
    .remain  (cur_remain),
    .len     (calc_len)
  );

  page_split_ctrl #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_count  (req_count),
    .req_erase  (req_erase),
    .range_bad  (range_bad),
    .calc_len   (calc_len),
    .chunk_ready(chunk_ready),
    .seq_done   (seq_done),
    .seq_err    (seq_err),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .chunk_valid(chunk_valid),
    .cur_addr   (cur_addr),
    .cur_remain (cur_remain),
    .erase_mode (erase_mode)
  );

  page_split_fill #(
    .DATA_W(DATA_W),
    .FILL  (FILL)
  ) fill_i (
    .erase_mode  (erase_mode),
    .seq_byte_rd (seq_byte_rd),
    .host_byte   (host_byte),
    .seq_byte    (seq_byte),
    .host_byte_rd(host_byte_rd)
  );

  assign chunk_addr  = cur_addr;
  assign chunk_len   = calc_len;
  assign chunk_erase = erase_mode;

endmodule

// File: rtl/page_split_chk.sv
module page_split_chk #(
  parameter int                ADDR_W     = 11,
  parameter int                CNT_W      = 12,
  parameter int                PAGE_BYTES = 16,
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] FILL       = '1,
  localparam int               OFS_W      = $clog2(PAGE_BYTES),
  localparam int               LEN_W      = OFS_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              chunk_valid,
  input logic              chunk_ready,
  input logic [ADDR_W-1:0] chunk_addr,
  input logic [LEN_W-1:0]  chunk_len,
  input logic              chunk_erase,
  input logic              seq_byte_rd,
  input logic [DATA_W-1:0] seq_byte,
  input logic              host_byte_rd
);

  p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_len != '0) &&
      (int'(chunk_addr[OFS_W-1:0]) + int'(chunk_len) <= PAGE_BYTES));

  p_erase_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chunk_erase && seq_byte_rd) |-> (seq_byte == FILL) && !host_byte_rd);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_chunk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready) |=>
      chunk_valid && $stable(chunk_addr) && $stable(chunk_len));

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && chunk_ready) |=> !chunk_valid);

endmodule

bind page_split_top page_split_chk #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .PAGE_BYTES(PAGE_BYTES),
  .DATA_W    (DATA_W),
  .FILL      (FILL)
) chk_i (.*);

// File: tb/page_split_top_tb_top.sv
module page_split_top_tb_top;

  localparam int AW   = 8;
  localparam int CW   = 9;
  localparam int MEM  = 256;
  localparam int PAGE = 8;
  localparam int LW   = 4;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [LW-1:0] l;
    logic          e;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_ready, req_erase;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_count;
  logic          busy, done, err;
  logic          chunk_valid, chunk_ready, chunk_erase;
  logic [AW-1:0] chunk_addr;
  logic [LW-1:0] chunk_len;
  logic          seq_done, seq_err, seq_byte_rd, host_byte_rd;
  logic [7:0]    seq_byte, host_byte;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   chunk_idx;
  int   fail_at;

  page_split_top #(
    .ADDR_W(AW), .CNT_W(CW), .MEM_BYTES(MEM), .PAGE_BYTES(PAGE), .DATA_W(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_count(req_count), .req_erase(req_erase),
    .busy(busy), .done(done), .err(err),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_addr(chunk_addr), .chunk_len(chunk_len), .chunk_erase(chunk_erase),
    .seq_done(seq_done), .seq_err(seq_err),
    .seq_byte_rd(seq_byte_rd), .seq_byte(seq_byte),
    .host_byte_rd(host_byte_rd), .host_byte(host_byte)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Sequencer model and scoreboard monitor
  initial begin
    exp_t          e;
    logic [AW-1:0] ha;
    logic [LW-1:0] hl;
    int            nb;
    chunk_ready = 1'b0; seq_done = 1'b0; seq_err = 1'b0;
    seq_byte_rd = 1'b0; host_byte = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n && chunk_valid) begin
        if (chunk_idx % 2 == 1) begin
          ha = chunk_addr; hl = chunk_len;
          @(negedge clk);
          chk(chunk_valid && chunk_addr == ha && chunk_len == hl,
              "R10 chunk held", int'(chunk_addr), int'(ha));
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected chunk", int'(chunk_addr), -1);
        end else begin
          e = exp_q.pop_front();
          chk(chunk_addr == e.a, "R2 chunk address", int'(chunk_addr), int'(e.a));
          chk(chunk_len == e.l, "R1 chunk length", int'(chunk_len), int'(e.l));
          chk(chunk_erase == e.e, e.e ? "R4 erase flag" : "R5 erase flag",
              int'(chunk_erase), int'(e.e));
        end
        nb = int'(chunk_len);
        chunk_ready = 1'b1;
        @(negedge clk);
        chunk_ready = 1'b0;
        chk(!chunk_valid, "R10 one outstanding", int'(chunk_valid), 0);
        for (int i = 0; i < nb; i++) begin
          seq_byte_rd = 1'b1;
          host_byte   = {1'b0, 7'(i * 5 + chunk_idx * 3 + 1)};
          #1;
          if (chunk_erase) begin
            chk(seq_byte == 8'hFF && !host_byte_rd, "R4 fill byte",
                int'(seq_byte), 255);
          end else begin
            chk(seq_byte == host_byte && host_byte_rd, "R5 host byte",
                int'(seq_byte), int'(host_byte));
          end
          @(negedge clk);
        end
        seq_byte_rd = 1'b0;
        seq_done = 1'b1;
        seq_err  = (chunk_idx == fail_at);
        chunk_idx++;
        @(negedge clk);
        seq_done = 1'b0;
        seq_err  = 1'b0;
      end
    end
  end

  // Driver: pushes expected chunks, issues request, checks completion
  task automatic run_req(input int addr, input int cnt, input bit erase,
                         input int fail, input bit poke, input string tag);
    int a = addr;
    int rem = cnt;
    int k = 0;
    int l;
    int t;
    bit exp_err = 1'b0;
    bit immediate = 1'b0;
    if (cnt == 0) begin
      immediate = 1'b1;
    end else if (addr + cnt > MEM) begin
      immediate = 1'b1; exp_err = 1'b1;
    end else begin
      while (rem > 0) begin
        l = PAGE - (a % PAGE);
        if (rem < l) l = rem;
        exp_q.push_back('{a: AW'(a), l: LW'(l), e: erase});
        if (k == fail) begin exp_err = 1'b1; break; end
        a += l; rem -= l; k++;
      end
    end
    chunk_idx = 0;
    fail_at   = fail;
    @(negedge clk);
    chk(req_ready && !busy, "R8 ready when idle", int'(req_ready), 1);
    req_addr = AW'(addr); req_count = CW'(cnt); req_erase = erase;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R8 busy after accept", int'(busy), 1);
    if (immediate) begin
      chk(done, {tag, " immediate done"}, int'(done), 1);
      chk(err == exp_err, {tag, " immediate err"}, int'(err), int'(exp_err));
    end else begin
      t = 0;
      while (!done && t < 5000) begin
        if (poke) begin
          req_valid = 1'b1; req_addr = 8'd1; req_count = 9'd3; req_erase = ~erase;
        end
        @(negedge clk);
        t++;
      end
      req_valid = 1'b0;
      chk(done, {tag, " completion"}, int'(done), 1);
      chk(err == exp_err, {tag, " err flag R3 R9"}, int'(err), int'(exp_err));
    end
    chk(exp_q.size() == 0, "R2 all chunks issued", exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R9 single pulse", int'(done), 0);
    chk(!busy && req_ready, "R8 idle after done", int'(busy), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired R11 actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_count = '0; req_erase = 1'b0;
    fail_at = -1; chunk_idx = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !chunk_valid && req_ready, "R11 in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !chunk_valid && req_ready, "R11 after reset", int'(busy), 0);

    run_req(5,   0,   1'b0, -1, 1'b0, "R7 zero length");
    run_req(0,   8,   1'b0, -1, 1'b0, "R1 aligned page");
    run_req(3,   20,  1'b0, -1, 1'b0, "R2 unaligned write");
    run_req(13,  13,  1'b1, -1, 1'b0, "R4 erase");
    run_req(2,   3,   1'b0, -1, 1'b0, "R1 inside page");
    run_req(6,   30,  1'b0, 1,  1'b0, "R3 mid failure");
    run_req(40,  9,   1'b1, 0,  1'b0, "R3 first failure");
    run_req(250, 7,   1'b0, -1, 1'b0, "R6 past end");
    run_req(0,   257, 1'b1, -1, 1'b0, "R6 count too large");
    run_req(250, 6,   1'b0, -1, 1'b0, "R6 ends at top");
    run_req(9,   17,  1'b0, -1, 1'b1, "R8 ignored while busy");
    run_req(0,   256, 1'b1, -1, 1'b0, "R4 whole memory erase");
    run_req(7,   1,   1'b0, -1, 1'b0, "R5 single byte");

    finish_run();
  end

endmodule